// File: doc/BRIEF.md
# Strict-Priority Class Multiplexer and Demultiplexer for a Shared Link

This block lets several kinds of traffic share one point-to-point link. On the transmit side each traffic class has its own small queue. Every time the link can take a new frame, a strict-priority arbiter picks the head word of the most urgent non-empty queue. That word goes out as a frame carrying a 2-bit class tag and a fixed-width payload. When no queue holds data, an idle frame is sent instead. Long messages are written into a queue one word at a time, so every word is a frame of its own. Arbitration therefore runs again at each frame boundary, and urgent traffic never waits behind the rest of a bulk transfer.

On the receive side the demultiplexer reads the tag of each incoming frame and presents the payload on the output stream of that class. Idle frames are consumed and produce no output. Data frames whose tag names a class the instance does not have are also consumed and produce no output.

The class count is a parameter, and class 0 is the most urgent. In the upstream direction the four classes are, in falling priority: track stubs, critical status, raw readout data and slow control. In the downstream direction `NUM_CLASSES=2` is used: trigger accept with its time marker, then slow control.

All stream interfaces are valid/ready. A word or frame transfers on a clock edge where both valid and ready are high. A sender holds its data stable while valid is high and ready is low. `tx_ready` from the link lets the link's own pace stall the multiplexer. The multiplexer holds its output frame until that frame is taken.

Top module: `clmux_link`

## Requirements
- R1: While `rst_n` is low, `tx_valid` is 0. After reset `tx_valid` stays 1, and an idle frame (kind bit 0) is presented whenever no class queue holds a word at load time.
- R2: Each class queue holds up to `QUEUE_DEPTH` words. Its `in_ready` bit is 1 while the queue is not full and 0 when it is full. A word offered while `in_ready` is 0 is not stored and never appears on the link.
- R3: A data frame of class c is loaded only if, at the moment of loading, every queue with a lower index (higher priority) is empty. Class 0 has the highest priority.
- R4: The words of one class leave on the link in the order in which they were accepted.
- R5: Frame layout (width `PAYLOAD_W+3`): bit `PAYLOAD_W+2` is the kind (1 = data, 0 = idle), bits `PAYLOAD_W+1:PAYLOAD_W` are the class tag, and the low `PAYLOAD_W` bits are the payload. An idle frame has tag and payload all zero.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_frame` is held unchanged.
- R7: Arbitration is repeated for every frame. A higher-priority word that is accepted while a lower class is draining a burst goes out ahead of the remaining burst words, right after the frame already loaded.
- R8: The receiver presents a valid data frame with tag t < `NUM_CLASSES` on output class t only: `out_valid` is one-hot at bit t, and `out_data` carries the payload. Idle frames raise no `out_valid` bit.
- R9: The receiver consumes a data frame whose tag is >= `NUM_CLASSES` (`rx_ready` = 1) and raises no `out_valid` bit.
- R10: For a routed data frame, `rx_ready` equals `out_ready` of the addressed class. Idle frames are always accepted (`rx_ready` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_CLASSES | Per-class word valid |
| in_ready | output | NUM_CLASSES | Per-class queue has room |
| in_data | input | NUM_CLASSES*PAYLOAD_W | Per-class word, class c at bits c*PAYLOAD_W upward |
| tx_valid | output | 1 | Link frame valid |
| tx_ready | input | 1 | Link takes the frame |
| tx_frame | output | PAYLOAD_W+3 | Outgoing frame {kind, tag, payload} |
| rx_valid | input | 1 | Incoming frame valid |
| rx_ready | output | 1 | Incoming frame consumed |
| rx_frame | input | PAYLOAD_W+3 | Incoming frame {kind, tag, payload} |
| out_valid | output | NUM_CLASSES | One-hot class output valid |
| out_ready | input | NUM_CLASSES | Per-class output ready |
| out_data | output | PAYLOAD_W | Payload of the routed frame |

## Verification
The bound checker watches four things on every cycle: that each frame loaded after a handshake respects strict priority against the queue state just before loading, that idle frames appear only when every queue was empty, that a stalled frame stays frozen, and that the receive side stays one-hot and routes or drops by tag with the correct ready. Some behaviour needs a scenario and cannot be seen in a single cycle: per-class ordering, a burst being overtaken at a frame boundary, a full queue refusing words so that the surplus never reaches the link, and the two-class downstream configuration discarding out-of-range tags. The bench's directed sequences and its table of receive vectors show these.

// File: rtl/clmux_pkg.sv
package clmux_pkg;
  localparam int TAG_W = 2;

  function automatic int frame_width(input int payload_w);
    return payload_w + TAG_W + 1;
  endfunction
endpackage

// File: rtl/clmux_fifo.sv
module clmux_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic             not_empty,
  output logic [WIDTH-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;
  logic             do_push, do_pop;

  assign push_ready = (fill != CW'(DEPTH));
  assign not_empty  = (fill != '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && not_empty;
  assign head       = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/clmux_arbiter.sv
module clmux_arbiter
  import clmux_pkg::*;
#(
  parameter int NUM_CLASSES = 4
) (
  input  logic [NUM_CLASSES-1:0] req,
  output logic [NUM_CLASSES-1:0] grant,
  output logic [TAG_W-1:0]       grant_idx,
  output logic                   any_req
);
  logic [NUM_CLASSES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any_req = seen[NUM_CLASSES];

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NUM_CLASSES; i++) begin
      if (grant[i]) grant_idx = TAG_W'(i);
    end
  end
endmodule

// File: rtl/clmux_rx_demux.sv
module clmux_rx_demux
  import clmux_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int PAYLOAD_W   = 16
) (
  input  logic                             rx_valid,
  output logic                             rx_ready,
  input  logic [PAYLOAD_W+TAG_W:0]         rx_frame,
  output logic [NUM_CLASSES-1:0]           out_valid,
  input  logic [NUM_CLASSES-1:0]           out_ready,
  output logic [PAYLOAD_W-1:0]             out_data
);
  logic             is_data;
  logic [TAG_W-1:0] tag;

  assign is_data  = rx_frame[PAYLOAD_W+TAG_W];
  assign tag      = rx_frame[PAYLOAD_W +: TAG_W];
  assign out_data = rx_frame[PAYLOAD_W-1:0];

  always_comb begin
    out_valid = '0;
    rx_ready  = 1'b1;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (rx_valid && is_data && tag == TAG_W'(c)) begin
        out_valid[c] = 1'b1;
        rx_ready     = out_ready[c];
      end
    end
  end
endmodule

// File: rtl/clmux_link.sv
module clmux_link
  import clmux_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int PAYLOAD_W   = 16,
  parameter int QUEUE_DEPTH = 4,
  localparam int FRAME_W    = PAYLOAD_W + TAG_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CLASSES-1:0]           in_valid,
  output logic [NUM_CLASSES-1:0]           in_ready,
  input  logic [NUM_CLASSES*PAYLOAD_W-1:0] in_data,
  output logic                             tx_valid,
  input  logic                             tx_ready,
  output logic [FRAME_W-1:0]               tx_frame,
  input  logic                             rx_valid,
  output logic                             rx_ready,
  input  logic [FRAME_W-1:0]               rx_frame,
  output logic [NUM_CLASSES-1:0]           out_valid,
  input  logic [NUM_CLASSES-1:0]           out_ready,
  output logic [PAYLOAD_W-1:0]             out_data
);
  logic [NUM_CLASSES-1:0] q_nonempty;
  logic [NUM_CLASSES-1:0] grant;
  logic [NUM_CLASSES-1:0] pop;
  logic [PAYLOAD_W-1:0]   head [NUM_CLASSES];
  logic [PAYLOAD_W-1:0]   sel_data;
  logic [TAG_W-1:0]       sel_tag;
  logic                   sel_any;
  logic                   load;

  assign load = tx_ready || !tx_valid;
  assign pop  = grant & {NUM_CLASSES{load}};

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_queue
    clmux_fifo #(
      .WIDTH(PAYLOAD_W),
      .DEPTH(QUEUE_DEPTH)
    ) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_valid(in_valid[c]),
      .push_ready(in_ready[c]),
      .push_data (in_data[c*PAYLOAD_W +: PAYLOAD_W]),
      .pop       (pop[c]),
      .not_empty (q_nonempty[c]),
      .head      (head[c])
    );
  end

  clmux_arbiter #(.NUM_CLASSES(NUM_CLASSES)) u_arb (
    .req      (q_nonempty),
    .grant    (grant),
    .grant_idx(sel_tag),
    .any_req  (sel_any)
  );

  always_comb begin
    sel_data = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (grant[c]) sel_data = head[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_frame <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_frame <= sel_any ? {1'b1, sel_tag, sel_data} : '0;
    end
  end

  clmux_rx_demux #(
    .NUM_CLASSES(NUM_CLASSES),
    .PAYLOAD_W  (PAYLOAD_W)
  ) u_rx (
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_frame (rx_frame),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );
endmodule

// File: rtl/clmux_link_chk.sv
module clmux_link_chk
  import clmux_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int PAYLOAD_W   = 16,
  localparam int FRAME_W    = PAYLOAD_W + TAG_W + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   tx_valid,
  input logic                   tx_ready,
  input logic [FRAME_W-1:0]     tx_frame,
  input logic [NUM_CLASSES-1:0] q_nonempty,
  input logic                   rx_valid,
  input logic                   rx_ready,
  input logic [FRAME_W-1:0]     rx_frame,
  input logic [NUM_CLASSES-1:0] out_valid,
  input logic [NUM_CLASSES-1:0] out_ready
);
  logic [TAG_W-1:0]       tx_tag, rx_tag;
  logic                   tx_kind, rx_kind;
  logic [NUM_CLASSES-1:0] hi_mask;
  logic                   rx_known;
  logic                   addr_ready;

  assign tx_kind = tx_frame[FRAME_W-1];
  assign tx_tag  = tx_frame[PAYLOAD_W +: TAG_W];
  assign rx_kind = rx_frame[FRAME_W-1];
  assign rx_tag  = rx_frame[PAYLOAD_W +: TAG_W];
  assign rx_known = ({1'b0, rx_tag} < (TAG_W+1)'(NUM_CLASSES));

  always_comb begin
    hi_mask    = '0;
    addr_ready = 1'b0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (TAG_W'(c) < tx_tag) hi_mask[c] = 1'b1;
      if (TAG_W'(c) == rx_tag) addr_ready = out_ready[c];
    end
  end

  p_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_kind || (($past(q_nonempty) & hi_mask) == '0)));

  p_idle_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_kind || ($past(q_nonempty) == '0)));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_kind) |-> (tx_frame[FRAME_W-2:0] == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_frame)));

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_kind && !rx_known) |-> (out_valid == '0 && rx_ready));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_kind && rx_known) |-> (rx_ready == addr_ready));

  p_idle_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_kind) |-> (rx_ready && out_valid == '0));
endmodule

bind clmux_link clmux_link_chk #(
  .NUM_CLASSES(NUM_CLASSES),
  .PAYLOAD_W  (PAYLOAD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_frame  (tx_frame),
  .q_nonempty(q_nonempty),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_frame  (rx_frame),
  .out_valid (out_valid),
  .out_ready (out_ready)
);

// File: tb/clmux_link_test.sv
module clmux_link_test;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int D  = 4;
  localparam int FW = W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]   in_valid = '0;
  logic [N-1:0]   in_ready;
  logic [N*W-1:0] in_data = '0;
  logic           tx_valid;
  logic           tx_ready = 1'b0;
  logic [FW-1:0]  tx_frame;
  logic           rx_valid = 1'b0;
  logic           rx_ready;
  logic [FW-1:0]  rx_frame = '0;
  logic [N-1:0]   out_valid;
  logic [N-1:0]   out_ready = '0;
  logic [W-1:0]   out_data;

  clmux_link #(.NUM_CLASSES(N), .PAYLOAD_W(W), .QUEUE_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_frame(tx_frame), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_frame(rx_frame), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  // Downstream configuration: two classes
  logic [1:0]    dn_in_valid = '0;
  logic [1:0]    dn_in_ready;
  logic [2*W-1:0] dn_in_data = '0;
  logic          dn_tx_valid;
  logic [FW-1:0] dn_tx_frame;
  logic          dn_rx_valid = 1'b0;
  logic          dn_rx_ready;
  logic [FW-1:0] dn_rx_frame = '0;
  logic [1:0]    dn_out_valid;
  logic [1:0]    dn_out_ready = 2'b11;
  logic [W-1:0]  dn_out_data;

  clmux_link #(.NUM_CLASSES(2), .PAYLOAD_W(W), .QUEUE_DEPTH(D)) uut_dn (
    .clk(clk), .rst_n(rst_n), .in_valid(dn_in_valid), .in_ready(dn_in_ready),
    .in_data(dn_in_data), .tx_valid(dn_tx_valid), .tx_ready(1'b1),
    .tx_frame(dn_tx_frame), .rx_valid(dn_rx_valid), .rx_ready(dn_rx_ready),
    .rx_frame(dn_rx_frame), .out_valid(dn_out_valid), .out_ready(dn_out_ready),
    .out_data(dn_out_data));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Link monitor: records data frames taken by the link
  logic [1:0] cap_tag [0:31];
  logic [7:0] cap_dat [0:31];
  int  cap_n = 0;
  bit  mon_en = 1'b0;
  always begin
    @(negedge clk);
    #1;
    if (mon_en && tx_valid && tx_ready && tx_frame[FW-1] && cap_n < 32) begin
      cap_tag[cap_n] = tx_frame[W +: 2];
      cap_dat[cap_n] = tx_frame[W-1:0];
      cap_n++;
    end
  end

  // Called at a negedge; holds the inputs for one cycle
  task automatic drive(input logic [N-1:0] v, input logic [N*W-1:0] d);
    in_valid = v;
    in_data  = d;
    @(negedge clk);
  endtask

  task automatic cap_chk(input string what, input int idx, input logic [1:0] t, input logic [7:0] d);
    chk(what, {22'd0, cap_tag[idx], cap_dat[idx]}, {22'd0, t, d});
  endtask

  // Receive vectors: {out_ready[3:0], frame[10:0], exp_out_valid[3:0], exp_rx_ready}
  localparam int NV = 8;
  localparam logic [19:0] RXV [NV] = '{
    {4'b1111, 1'b0, 2'd0, 8'h00, 4'b0000, 1'b1},
    {4'b1111, 1'b1, 2'd0, 8'h11, 4'b0001, 1'b1},
    {4'b1111, 1'b1, 2'd3, 8'hA5, 4'b1000, 1'b1},
    {4'b0000, 1'b1, 2'd2, 8'h3C, 4'b0100, 1'b0},
    {4'b1011, 1'b1, 2'd2, 8'h7E, 4'b0100, 1'b0},
    {4'b0100, 1'b1, 2'd2, 8'h7E, 4'b0100, 1'b1},
    {4'b0000, 1'b0, 2'd3, 8'hFF, 4'b0000, 1'b1},
    {4'b1101, 1'b1, 2'd1, 8'h42, 4'b0010, 1'b0}
  };

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] held;

    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 tx_valid in reset", {31'd0, tx_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid after reset", {31'd0, tx_valid}, 32'd1);
    chk("R1/R5 idle frame", {21'd0, tx_frame}, 32'd0);
    chk("R2 queues ready", {28'd0, in_ready}, {28'd0, 4'b1111});

    // Table of receive vectors: R8/R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      out_ready = RXV[i][19:16];
      rx_frame  = RXV[i][15:5];
      rx_valid  = 1'b1;
      #1;
      chk($sformatf("R8 out_valid vec %0d", i), {28'd0, out_valid}, {28'd0, RXV[i][4:1]});
      chk($sformatf("R10 rx_ready vec %0d", i), {31'd0, rx_ready}, {31'd0, RXV[i][0]});
      if (RXV[i][4:1] != '0)
        chk($sformatf("R8 out_data vec %0d", i), {24'd0, out_data}, {24'd0, RXV[i][12:5]});
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_frame = {1'b1, 2'd1, 8'h55};
    out_ready = 4'b1111;
    #1;
    chk("R8 no output without rx_valid", {28'd0, out_valid}, 32'd0);

    // Scenario: stall, load all classes, then release (R3 R4 R5 R6)
    @(negedge clk);
    tx_ready = 1'b0;
    @(negedge clk);
    held = tx_frame;
    drive(4'b1001, {8'hA0, 8'h00, 8'h00, 8'h51});
    drive(4'b1100, {8'hA1, 8'hB0, 8'h00, 8'h00});
    drive(4'b1000, {8'hA2, 8'h00, 8'h00, 8'h00});
    in_valid = '0;
    #1;
    chk("R6 frame held under stall", {21'd0, tx_frame}, {21'd0, held});
    chk("R6 valid held under stall", {31'd0, tx_valid}, 32'd1);
    cap_n = 0;
    mon_en = 1'b1;
    @(negedge clk);
    tx_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 frame count", cap_n, 32'd5);
    cap_chk("R3 first is class 0", 0, 2'd0, 8'h51);
    cap_chk("R3 second is class 2", 1, 2'd2, 8'hB0);
    cap_chk("R4 class 3 word 0", 2, 2'd3, 8'hA0);
    cap_chk("R4 class 3 word 1", 3, 2'd3, 8'hA1);
    cap_chk("R4 class 3 word 2", 4, 2'd3, 8'hA2);
    #1;
    chk("R1 idle after drain", {21'd0, tx_frame}, 32'd0);

    // Scenario: preemption at a frame boundary (R7)
    cap_n = 0;
    drive(4'b1000, {8'hC0, 8'h00, 8'h00, 8'h00});
    drive(4'b1010, {8'hC1, 8'h00, 8'hD0, 8'h00});
    drive(4'b1000, {8'hC2, 8'h00, 8'h00, 8'h00});
    drive(4'b1000, {8'hC3, 8'h00, 8'h00, 8'h00});
    in_valid = '0;
    repeat (10) @(negedge clk);
    chk("R7 frame count", cap_n, 32'd5);
    cap_chk("R7 burst head first", 0, 2'd3, 8'hC0);
    cap_chk("R7 urgent word overtakes", 1, 2'd1, 8'hD0);
    cap_chk("R7 burst resumes", 2, 2'd3, 8'hC1);
    cap_chk("R7 burst tail", 4, 2'd3, 8'hC3);

    // Scenario: queue full (R2)
    tx_ready = 1'b0;
    @(negedge clk);
    cap_n = 0;
    for (int k = 0; k < D; k++)
      drive(4'b0010, {16'h0, 8'hE0 + 8'(k), 8'h00});
    #1;
    chk("R2 full queue not ready", {31'd0, in_ready[1]}, 32'd0);
    chk("R2 other queues ready", {29'd0, in_ready[3:2], in_ready[0]}, {29'd0, 3'b111});
    drive(4'b0010, {16'h0, 8'hEF, 8'h00});
    in_valid = '0;
    tx_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2 only stored words sent", cap_n, D);
    for (int k = 0; k < D; k++)
      cap_chk("R2/R4 stored word", k, 2'd1, 8'hE0 + 8'(k));
    mon_en = 1'b0;

    // Downstream two-class instance: out-of-range tags dropped (R9)
    @(negedge clk);
    dn_rx_valid = 1'b1;
    dn_out_ready = 2'b00;
    dn_rx_frame = {1'b1, 2'd3, 8'h99};
    #1;
    chk("R9 tag 3 no output", {30'd0, dn_out_valid}, 32'd0);
    chk("R9 tag 3 consumed", {31'd0, dn_rx_ready}, 32'd1);
    @(negedge clk);
    dn_rx_frame = {1'b1, 2'd2, 8'h98};
    #1;
    chk("R9 tag 2 no output", {30'd0, dn_out_valid}, 32'd0);
    chk("R9 tag 2 consumed", {31'd0, dn_rx_ready}, 32'd1);
    @(negedge clk);
    dn_out_ready = 2'b10;
    dn_rx_frame = {1'b1, 2'd1, 8'h97};
    #1;
    chk("R8 two-class routing", {30'd0, dn_out_valid}, {30'd0, 2'b10});
    chk("R10 two-class ready", {31'd0, dn_rx_ready}, 32'd1);
    @(negedge clk);
    dn_rx_valid = 1'b0;

    // Downstream transmit: accept beats slow control (R3)
    drive('0, '0);
    dn_in_valid = 2'b11;
    dn_in_data  = {8'h5C, 8'hAC};
    @(negedge clk);
    dn_in_valid = 2'b00;
    @(negedge clk);
    #1;
    chk("R3 two-class accept first", {21'd0, dn_tx_frame}, {21'd0, 1'b1, 2'd0, 8'hAC});
    @(negedge clk);
    #1;
    chk("R3 two-class slow control next", {21'd0, dn_tx_frame}, {21'd0, 1'b1, 2'd1, 8'h5C});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule